// File: doc/BRIEF.md
# Security-Grouped Interrupt Signaller

This block collects a parameterised number of interrupt sources and drives two processor interrupt lines, a normal request (IRQ) and a fast request (FIQ). Each source is placed in one of three security groups by two configuration bits: a group bit and a group-modifier bit. Which line a pending source raises depends on its group and on the processor's current security state. A source that is pending and enabled in a group that belongs to the processor's current world raises IRQ. A source that needs a world switch or firmware attention raises FIQ.

Software reaches the block through a simple word-wide register port. Every access carries a security attribute. Secure accesses see and change every source. Non-secure accesses see only the bits of Non-secure sources; all other bits read as zero. Their writes to any other bit are dropped silently, and no error is reported. The group and group-modifier registers accept writes only from Secure accesses, and a Secure access may regroup a source at any time while the block runs.

Top module: `secgrp_intc`

## Requirements
- R1: A source's group comes from its bit in the group register (offset 0) and its bit in the modifier register (offset 1). Group bit 1 gives Non-secure Group 1 whatever the modifier. Group 0 with modifier 0 gives Group 0. Group 0 with modifier 1 gives Secure Group 1.
- R2: An enabled, pending Group 0 source asserts `fiq_o` and not `irq_o` in either processor security state.
- R3: An enabled, pending Secure Group 1 source asserts `irq_o` when `cpu_ns` is 0 and `fiq_o` when `cpu_ns` is 1.
- R4: An enabled, pending Non-secure Group 1 source asserts `fiq_o` when `cpu_ns` is 0 and `irq_o` when `cpu_ns` is 1.
- R5: Each output is the OR over all sources that are both enabled and pending and routed to that line. A pending source that is disabled drives neither line.
- R6: After reset every source is Group 0 with modifier 0, disabled and not pending, and both outputs are 0.
- R7: Writes to the group or modifier register with `bus_ns`=1 leave both registers unchanged.
- R8: When `bus_ns`=1, every register reads as zero in the bit of each source whose group bit is 0.
- R9: With `bus_ns`=1, writes to enable-set (offset 2), enable-clear (3), pending-set (4) and pending-clear (5) change only the bits of sources whose group bit is 1.
- R10: Set registers are write-one-to-set and clear registers are write-one-to-clear. Zero bits leave a source unchanged. Reads of offsets 2 and 3 return the enables, and reads of offsets 4 and 5 return the pending bits.
- R11: A high `src_irq` bit makes that source pending on the next edge. In the same cycle this hardware set wins over a software pending-clear.
- R12: A Secure regroup of an enabled, pending source moves its request to the line of the new group on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ns | input | 1 | Processor security state, 1 = Non-secure |
| src_irq | input | NUM_SRC | Per-source hardware pending request, level |
| bus_we | input | 1 | Register write strobe |
| bus_ns | input | 1 | Access security attribute, 1 = Non-secure |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | NUM_SRC | Write data, one bit per source |
| bus_rdata | output | NUM_SRC | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request line |
| fiq_o | output | 1 | Fast interrupt request line |

## Verification
Two things can land in one cycle: a hardware request on `src_irq` and a software write to the pending-clear register for the same source. The bench holds `src_irq` high across the clock edge that takes the clear. It then reads the pending bits back and expects the source to still be pending, so the hardware set has won. A second collision is a Non-secure clear of all bits while Secure sources are pending. Reading back through a Secure access shows that only the Non-secure bit dropped.

// File: rtl/secgrp_pkg.sv
package secgrp_pkg;

  typedef enum logic [1:0] {
    GRP_SEC0   = 2'd0,
    GRP_SEC1   = 2'd1,
    GRP_NSEC1  = 2'd2
  } grp_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_GROUP  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_MODIF  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_PD_SET = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_PD_CLR = 3'd5;

  // Group bit set means Non-secure whatever the modifier holds.
  function automatic grp_e grp_decode(input logic grp_bit, input logic mod_bit);
    if (grp_bit)      return GRP_NSEC1;
    else if (mod_bit) return GRP_SEC1;
    else              return GRP_SEC0;
  endfunction

  // 1 = the source uses the fast line in this processor state.
  function automatic logic uses_fast_line(input grp_e grp, input logic cpu_nonsec);
    case (grp)
      GRP_SEC0:  return 1'b1;
      GRP_SEC1:  return cpu_nonsec;
      GRP_NSEC1: return ~cpu_nonsec;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/secgrp_cfg.sv
module secgrp_cfg
  import secgrp_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic               bus_ns,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] grp_q,
  output logic [NUM_SRC-1:0] mod_q
);

  logic hit_group;
  logic hit_modif;
  logic cfg_wr_ok;
  logic cfg_wr_dropped;

  assign hit_group      = bus_we && (bus_addr == OFS_GROUP);
  assign hit_modif      = bus_we && (bus_addr == OFS_MODIF);
  assign cfg_wr_ok      = (hit_group || hit_modif) && !bus_ns;
  assign cfg_wr_dropped = (hit_group || hit_modif) && bus_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      mod_q <= '0;
    end else if (cfg_wr_ok) begin
      if (hit_group) grp_q <= bus_wdata;
      if (hit_modif) mod_q <= bus_wdata;
    end
  end

  AST_NS_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_dropped |=> ($stable(grp_q) && $stable(mod_q))); // R7

  AST_SEC_CFG_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_ok && hit_group) |=> (grp_q == $past(bus_wdata))); // R7

endmodule

// File: rtl/secgrp_state.sv
module secgrp_state
  import secgrp_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic               bus_ns,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  input  logic [NUM_SRC-1:0] nsec_src,
  input  logic [NUM_SRC-1:0] src_irq,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] active
);

  logic [NUM_SRC-1:0] wr_mask;
  logic [NUM_SRC-1:0] eff_data;
  logic [NUM_SRC-1:0] en_set, en_clr, pd_set, pd_clr;
  logic [NUM_SRC-1:0] en_nxt, pend_nxt;

  // A Non-secure access reaches only the bits of Non-secure sources.
  assign wr_mask  = bus_ns ? nsec_src : {NUM_SRC{1'b1}};
  assign eff_data = bus_wdata & wr_mask;

  assign en_set = (bus_we && bus_addr == OFS_EN_SET) ? eff_data : '0;
  assign en_clr = (bus_we && bus_addr == OFS_EN_CLR) ? eff_data : '0;
  assign pd_set = (bus_we && bus_addr == OFS_PD_SET) ? eff_data : '0;
  assign pd_clr = (bus_we && bus_addr == OFS_PD_CLR) ? eff_data : '0;

  // Hardware request is applied last, so it wins over a software clear.
  assign en_nxt   = (en_q | en_set) & ~en_clr;
  assign pend_nxt = ((pend_q | pd_set) & ~pd_clr) | src_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign active = en_q & pend_q;

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_irq) |=> ((pend_q & $past(src_irq)) == $past(src_irq))); // R11

  AST_NS_KEEPS_SEC_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_ns && bus_addr == OFS_PD_CLR)
      |=> (($past(pend_q) & ~$past(nsec_src) & ~pend_q) == '0)); // R9

  AST_NS_KEEPS_SEC_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_ns && bus_addr == OFS_EN_SET)
      |=> ((en_q & ~$past(en_q) & ~$past(nsec_src)) == '0)); // R9

  AST_SEC_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_ns && bus_addr == OFS_EN_SET)
      |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata))); // R10

endmodule

// File: rtl/secgrp_route.sv
module secgrp_route
  import secgrp_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] grp_q,
  input  logic [NUM_SRC-1:0] mod_q,
  input  logic [NUM_SRC-1:0] active,
  input  logic               cpu_ns,
  output logic [NUM_SRC-1:0] to_fast,
  output logic [NUM_SRC-1:0] to_norm,
  output logic               irq_o,
  output logic               fiq_o
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    grp_e grp_i;
    logic fast_i;
    assign grp_i      = grp_decode(grp_q[i], mod_q[i]);
    assign fast_i     = uses_fast_line(grp_i, cpu_ns);
    assign to_fast[i] = active[i] &  fast_i;
    assign to_norm[i] = active[i] & ~fast_i;
  end

  assign irq_o = |to_norm;
  assign fiq_o = |to_fast;

endmodule

// File: rtl/secgrp_intc.sv
module secgrp_intc
  import secgrp_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_ns,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               bus_we,
  input  logic               bus_ns,
  input  logic [2:0]         bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);

  logic [NUM_SRC-1:0] grp_q, mod_q;
  logic [NUM_SRC-1:0] en_q, pend_q, active;
  logic [NUM_SRC-1:0] to_fast, to_norm;
  logic [NUM_SRC-1:0] rd_raw;
  logic [NUM_SRC-1:0] grp0_mask;

  secgrp_cfg #(.NUM_SRC(NUM_SRC)) cfg_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_ns(bus_ns),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .grp_q(grp_q), .mod_q(mod_q)
  );

  secgrp_state #(.NUM_SRC(NUM_SRC)) state_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_ns(bus_ns),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .nsec_src(grp_q),
    .src_irq(src_irq), .en_q(en_q), .pend_q(pend_q), .active(active)
  );

  secgrp_route #(.NUM_SRC(NUM_SRC)) route_i (
    .grp_q(grp_q), .mod_q(mod_q), .active(active), .cpu_ns(cpu_ns),
    .to_fast(to_fast), .to_norm(to_norm), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always_comb begin
    case (bus_addr)
      OFS_GROUP:               rd_raw = grp_q;
      OFS_MODIF:               rd_raw = mod_q;
      OFS_EN_SET, OFS_EN_CLR:  rd_raw = en_q;
      OFS_PD_SET, OFS_PD_CLR:  rd_raw = pend_q;
      default:                 rd_raw = '0;
    endcase
  end

  assign bus_rdata = bus_ns ? (rd_raw & grp_q) : rd_raw;
  assign grp0_mask = ~grp_q & ~mod_q;

  AST_NS_READ_HIDES_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ns |-> ((bus_rdata & ~grp_q) == '0)); // R8

  AST_G0_ALWAYS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (|(active & grp0_mask)) |-> fiq_o); // R2

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (!irq_o && !fiq_o)); // R5

  AST_ONE_LINE_PER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (to_fast & to_norm) == '0); // R3

  AST_NS1_NORMAL_IN_NS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ns && |(active & grp_q)) |-> irq_o); // R4

endmodule

// File: tb/secgrp_intc_tb.sv
`timescale 1ns/1ps
module secgrp_intc_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_ns = 1'b0;
  logic [N-1:0] src_irq = '0;
  logic         bus_we = 1'b0;
  logic         bus_ns = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         irq_o, fiq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  secgrp_intc #(.NUM_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_ns(cpu_ns), .src_irq(src_irq),
    .bus_we(bus_we), .bus_ns(bus_ns), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // {group bit, modifier bit, cpu_ns, expected irq, expected fiq}
  localparam logic [4:0] VEC [8] = '{
    5'b000_01, 5'b001_01, 5'b010_10, 5'b011_01,
    5'b100_01, 5'b101_10, 5'b111_10, 5'b110_01
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; src_irq = '0; cpu_ns = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic ns, input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_ns = ns; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic ns, input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_ns = ns; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    do_reset();

    // R6: reset state
    chk("R6 irq", irq_o, 0);
    chk("R6 fiq", fiq_o, 0);
    rd(1'b0, 3'd0, r); chk("R6 group", r, 0);
    rd(1'b0, 3'd1, r); chk("R6 modif", r, 0);
    rd(1'b0, 3'd2, r); chk("R6 enable", r, 0);
    rd(1'b0, 3'd4, r); chk("R6 pending", r, 0);

    // R1 R2 R3 R4: routing table on source 0
    for (int k = 0; k < 8; k++) begin
      do_reset();
      wr(1'b0, 3'd0, {7'b0, VEC[k][4]});
      wr(1'b0, 3'd1, {7'b0, VEC[k][3]});
      wr(1'b0, 3'd2, 8'h01);
      wr(1'b0, 3'd4, 8'h01);
      @(negedge clk); cpu_ns = VEC[k][2];
      #1;
      chk($sformatf("R1/R2/R3/R4 vec%0d irq", k), irq_o, VEC[k][1]);
      chk($sformatf("R1/R2/R3/R4 vec%0d fiq", k), fiq_o, VEC[k][0]);
    end

    // R5: disabled pending source drives nothing
    wr(1'b0, 3'd3, 8'h01);
    chk("R5 disabled irq", irq_o, 0);
    chk("R5 disabled fiq", fiq_o, 0);

    // R5: two sources on different lines at once (cpu secure)
    do_reset();
    wr(1'b0, 3'd1, 8'h04);           // src2 Secure Group 1, src5 Group 0
    wr(1'b0, 3'd2, 8'h24);
    wr(1'b0, 3'd4, 8'h24);
    chk("R5 both irq", irq_o, 1);
    chk("R5 both fiq", fiq_o, 1);

    // R7: Non-secure writes to config dropped
    do_reset();
    wr(1'b1, 3'd0, 8'hFF);
    wr(1'b1, 3'd1, 8'hFF);
    rd(1'b0, 3'd0, r); chk("R7 group after NS write", r, 0);
    rd(1'b0, 3'd1, r); chk("R7 modif after NS write", r, 0);
    wr(1'b0, 3'd0, 8'h02);
    rd(1'b0, 3'd0, r); chk("R7 secure group write", r, 8'h02);

    // R8: NS view masks Secure sources
    wr(1'b0, 3'd4, 8'hFF);
    rd(1'b1, 3'd4, r); chk("R8 NS pending view", r, 8'h02);
    rd(1'b0, 3'd4, r); chk("R8 secure pending view", r, 8'hFF);
    rd(1'b1, 3'd0, r); chk("R8 NS group view", r, 8'h02);

    // R9: NS set/clear only reach Non-secure sources
    wr(1'b1, 3'd5, 8'hFF);
    rd(1'b0, 3'd4, r); chk("R9 NS pend clear", r, 8'hFD);
    wr(1'b1, 3'd2, 8'hFF);
    rd(1'b0, 3'd2, r); chk("R9 NS enable set", r, 8'h02);

    // R10: W1S / W1C, zero bits inert
    wr(1'b0, 3'd2, 8'h01);
    wr(1'b0, 3'd2, 8'h04);
    rd(1'b0, 3'd3, r); chk("R10 enable set", r, 8'h07);
    wr(1'b0, 3'd3, 8'h02);
    rd(1'b0, 3'd2, r); chk("R10 enable clear", r, 8'h05);

    // R11: hardware set, and collision with software clear
    do_reset();
    @(negedge clk); src_irq = 8'h08;
    @(negedge clk); src_irq = '0;
    rd(1'b0, 3'd4, r); chk("R11 hw set", r, 8'h08);
    @(negedge clk);
    src_irq = 8'h08;
    bus_we = 1'b1; bus_ns = 1'b0; bus_addr = 3'd5; bus_wdata = 8'h08;
    @(negedge clk);
    bus_we = 1'b0; src_irq = '0;
    rd(1'b0, 3'd4, r); chk("R11 set beats clear", r, 8'h08);
    wr(1'b0, 3'd5, 8'h08);
    rd(1'b0, 3'd4, r); chk("R11 clear after release", r, 0);

    // R12: run-time regroup moves the request
    do_reset();
    wr(1'b0, 3'd2, 8'h01);
    wr(1'b0, 3'd4, 8'h01);
    @(negedge clk); cpu_ns = 1'b1;
    #1;
    chk("R12 before irq", irq_o, 0);
    chk("R12 before fiq", fiq_o, 1);
    wr(1'b0, 3'd0, 8'h01);
    chk("R12 after irq", irq_o, 1);
    chk("R12 after fiq", fiq_o, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule